// File: doc/BRIEF.md
# SHA-1 Block Compression Engine with Precomputed Step Terms

This block applies the SHA-1 compression function to one 512-bit message block and a 160-bit chaining value, producing the updated 160-bit chaining value. It uses a single step datapath, reused across the 80 steps. Padding, framing of multi-block messages and any keyed wrapper are left to the surrounding logic. A caller starts a compression and waits for the done pulse. It then feeds the result back through `cv_in` for the next block, or restarts from the standard initial value.

To shorten the register-to-register path, the block registers two terms one cycle ahead of each step. The first is the sum of the incoming e word, the round constant and the schedule word. The second is the round's nonlinear function of the incoming b, c and d words. The adder that forms the new a word therefore sums only three operands: the rotated a, the stored sum and the stored function value. One extra register holds the function value. A single setup cycle after start fills these registers for step 0. The 16-word message schedule is kept in a shift register inside the block.

Top module: `sha1_precomp_core`

## Requirements
- R1: After reset, `done` is low and `cv_out` equals the standard initial value 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0, with the first word in bits 159:128.
- R2: With `iv_sel` high at start, the result is the SHA-1 compression of `blk_in` with the standard initial value. Message word 0 is `blk_in[511:480]`, in big-endian word order. The padded block for "abc" gives A9993E36 4706816A BA3E2571 7850C26C 9CD0D89D.
- R3: With `iv_sel` low at start, the compression chains from `cv_in`, whose first word is in bits 159:128.
- R4: When `start` is sampled while idle, `done` rises exactly 82 clock edges later, stays high for one cycle, and `cv_out` presents the result from that cycle onward.
- R5: A `start` pulse that arrives while a compression is in progress is ignored, and the result and timing of the running compression are unchanged.
- R6: `cv_out` keeps its previous value throughout a compression until the cycle in which `done` is high.
- R7: `blk_in`, `cv_in` and `iv_sel` are sampled only on the accepted start edge, so changes to them during a compression have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a compression when idle |
| iv_sel | input | 1 | 1: chain from the standard initial value; 0: chain from cv_in |
| blk_in | input | 512 | Message block, word 0 in the top bits |
| cv_in | input | 160 | Chaining value input |
| cv_out | output | 160 | Updated chaining value |
| done | output | 1 | One-cycle pulse when cv_out is updated |

## Verification
The only timed results are `done` and `cv_out`, and both are due 82 edges after an accepted start. The bench counts rising edges from the start edge. It samples one time unit after each edge, requires `done` low and `cv_out` unchanged for edges 1 to 81, and compares the digest with a bench-side reference compression at edge 82. It then checks that `done` has dropped one edge later. For the busy-start and input-perturbation cases, the same count is kept, which shows that the extra stimulus neither moves the pulse nor changes the digest.

// File: rtl/sha1_precomp_core.sv
module sha1_precomp_core #(
  parameter int STEPS = 80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         iv_sel,
  input  logic [511:0] blk_in,
  input  logic [159:0] cv_in,
  output logic [159:0] cv_out,
  output logic         done
);
  localparam int SW = $clog2(STEPS + 1);
  localparam logic [159:0] IV = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;
  localparam logic [1:0] S_IDLE = 2'd0, S_PRE = 2'd1, S_RUN = 2'd2, S_FIN = 2'd3;

  function automatic logic [31:0] kconst(input logic [SW-1:0] t);
    if (t < 20)      kconst = 32'h5A827999;
    else if (t < 40) kconst = 32'h6ED9EBA1;
    else if (t < 60) kconst = 32'h8F1BBCDC;
    else             kconst = 32'hCA62C1D6;
  endfunction

  function automatic logic [31:0] fsel(input logic [SW-1:0] t,
                                       input logic [31:0] x, y, z);
    if (t < 20)                fsel = (x & y) | (~x & z);
    else if (t >= 40 && t < 60) fsel = (x & y) | (x & z) | (y & z);
    else                       fsel = x ^ y ^ z;
  endfunction

  logic [1:0]    st;
  logic [SW-1:0] step;
  logic [31:0]   a_q, b_q, c_q, d_q, e_q, ep_q, g_q;
  logic [31:0]   w [16];
  logic [159:0]  hin;

  wire pre = (st == S_PRE);
  wire [SW-1:0] pidx = pre ? '0 : SW'(step + 1'b1);
  wire [31:0] nb = pre ? b_q : a_q;
  wire [31:0] nc = pre ? c_q : {b_q[1:0], b_q[31:2]};
  wire [31:0] nd = pre ? d_q : c_q;
  wire [31:0] ne = pre ? e_q : d_q;
  wire [31:0] wx = w[13] ^ w[8] ^ w[2] ^ w[0];
  wire [31:0] wnew = {wx[30:0], wx[31]};
  wire [31:0] a_new = {a_q[26:0], a_q[31:27]} + ep_q + g_q;
  wire [159:0] chain = iv_sel ? IV : cv_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0; done <= 1'b0; cv_out <= IV; hin <= IV;
      a_q <= '0; b_q <= '0; c_q <= '0; d_q <= '0; e_q <= '0;
      ep_q <= '0; g_q <= '0;
      for (int i = 0; i < 16; i++) w[i] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          {a_q, b_q, c_q, d_q, e_q} <= chain;
          hin  <= chain;
          for (int i = 0; i < 16; i++) w[i] <= blk_in[511-32*i -: 32];
          step <= '0;
          st   <= S_PRE;
        end
        S_PRE, S_RUN: begin
          ep_q <= ne + kconst(pidx) + w[0];
          g_q  <= fsel(pidx, nb, nc, nd);
          for (int i = 0; i < 15; i++) w[i] <= w[i+1];
          w[15] <= wnew;
          if (pre) st <= S_RUN;
          else begin
            a_q <= a_new; b_q <= a_q; c_q <= {b_q[1:0], b_q[31:2]};
            d_q <= c_q;   e_q <= d_q;
            step <= SW'(step + 1'b1);
            if (step == SW'(STEPS - 1)) st <= S_FIN;
          end
        end
        default: begin
          cv_out <= {hin[159:128] + a_q, hin[127:96] + b_q, hin[95:64] + c_q,
                     hin[63:32] + d_q, hin[31:0] + e_q};
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_CV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(cv_out)); // R6
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step <= SW'(STEPS)); // R4
  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && st != S_FIN) |=> $stable(hin)); // R5
  AST_ROTATE_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_RUN && st != S_IDLE) |->
      (b_q == $past(a_q) && c_q == {$past(b_q[1:0]), $past(b_q[31:2])} && e_q == $past(d_q))); // R2
  AST_G_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> g_q == fsel(step, b_q, c_q, d_q)); // R2
endmodule

// File: tb/tb_sha1_precomp_core.sv
module tb_sha1_precomp_core;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, iv_sel = 1'b1;
  logic [511:0] blk_in = '0;
  logic [159:0] cv_in = '0;
  logic [159:0] cv_out;
  logic done;
  int n_tests = 0, n_fail = 0;
  localparam logic [159:0] IV = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

  always #2 clk = ~clk;

  sha1_precomp_core dut (.clk(clk), .rst_n(rst_n), .start(start), .iv_sel(iv_sel),
    .blk_in(blk_in), .cv_in(cv_in), .cv_out(cv_out), .done(done));

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    rl = (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_comp(input logic [159:0] h, input logic [511:0] m);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = m[511-32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    {a, b, c, d, e} = h;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    ref_comp = {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
  endfunction

  function automatic logic [511:0] rnd_blk();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
    rnd_blk = r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode 0: plain; 1: busy start + input perturbation (R5, R7)
  task automatic run_block(input logic [511:0] m, input logic [159:0] cv, input bit use_iv,
                           input int mode, input string req);
    logic [159:0] exp, old;
    bit lat_ok, hold_ok;
    exp = ref_comp(use_iv ? IV : cv, m);
    old = cv_out;
    lat_ok = 1'b1; hold_ok = 1'b1;
    blk_in = m; cv_in = cv; iv_sel = use_iv; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (mode == 1) begin blk_in = ~m; cv_in = ~cv; iv_sel = ~use_iv; end
    for (int i = 1; i <= 82; i++) begin
      if (mode == 1 && i == 40) start = 1'b1;
      if (mode == 1 && i == 41) start = 1'b0;
      @(posedge clk); #1;
      if (i < 82) begin
        if (done) lat_ok = 1'b0;
        if (cv_out !== old) hold_ok = 1'b0;
      end
    end
    check(lat_ok && done === 1'b1, "R4 done timing", {159'd0, done}, 160'd1);
    check(hold_ok, "R6 cv_out hold", cv_out, old);
    check(cv_out === exp, req, cv_out, exp);
    @(posedge clk); #1;
    check(done === 1'b0, "R4 single pulse", {159'd0, done}, 160'd0);
    if (mode == 1) begin
      repeat (3) @(posedge clk);
      #1 check(done === 1'b0 && cv_out === exp, "R5/R7 no second run", cv_out, exp);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] abc;
    logic [159:0] prev;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check(done === 1'b0 && cv_out === IV, "R1 reset state", cv_out, IV);
    rst_n = 1'b1;
    @(posedge clk); #1;
    abc = '0;
    abc[511:480] = 32'h61626380;
    abc[31:0] = 32'h00000018;
    run_block(abc, '0, 1'b1, 0, "R2 abc digest");
    check(cv_out === 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D, "R2 abc constant",
          cv_out, 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);
    prev = cv_out;
    run_block(rnd_blk(), prev, 1'b0, 0, "R3 chained from cv_in");
    run_block('0, 160'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 1'b0, 0, "R3 all-ones chain");
    run_block({512{1'b1}}, '0, 1'b1, 0, "R2 all-ones block");
    run_block(rnd_blk(), {$urandom, $urandom, $urandom, $urandom, $urandom}, 1'b1, 1, "R5 R7 busy start");
    run_block(rnd_blk(), {$urandom, $urandom, $urandom, $urandom, $urandom}, 1'b0, 1, "R7 R3 perturbed chain");
    for (int n = 0; n < 20; n++) begin
      bit s;
      s = $urandom % 2;
      run_block(rnd_blk(), {$urandom, $urandom, $urandom, $urandom, $urandom}, s, 0,
                s ? "R2 random" : "R3 random");
      repeat ($urandom % 3) @(posedge clk);
      #1;
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule